// File: doc/BRIEF.md
# Switched-Capacitor Inverter Switch Sequencer

This block drives the gates of a switched-capacitor boost inverter with three pumping capacitors, twelve topology switches and one modulated output switch. From the clock it builds two non-overlapping phases. In the charge phase all three capacitors are placed in parallel across the supply. In the discharge phase the supply and some of the capacitors are stacked in series toward the output, giving a boost of 1x, 2x, 3x or 4x. An all-off gap of programmable length separates every phase change, so no two switch groups conduct at the same time.

The boost ratio is picked from the wanted output peak, which keeps efficiency up at low outputs. With a 5 V supply, a 5 V peak uses 1x, 10 V uses 2x, 15 V uses 3x and 20 V uses 4x. A polarity flag selects the positive or the negative half-wave. Each combination of ratio and polarity gives the discharge phase its own series path. The gain code and the polarity are captured only when a charge phase begins, so the topology never changes partway through a cycle. The modulated output switch follows an external duty bit, and only inside the discharge phase.

Top module: `sc_inv_sequencer`

## Requirements
- R1: `phase1` and `phase2` are never high together. In every gap between phases both are low and all of `sw_en` and `mod_en` are low.
- R2: Each gap lasts `dead_cycles` clock cycles. A value of 0 is treated as 1.
- R3: Each phase lasts `phase_cycles` clock cycles. A value of 0 is treated as 1.
- R4: In phase 1 with `neg_half`=0, `sw_en` is on for S1, S2, S3, S4, S9, S10 and S11 and off for every other switch. Bit k-1 of `sw_en` drives switch Sk.
- R5: In phase 1 with `neg_half`=1, `sw_en` is on for S2, S3, S4, S9, S10, S11 and S12 and off for every other switch.
- R6: In phase 2 of the positive half-wave, S5, S6 and S7 are on, plus one switch that depends on the gain. The gain code is 0=1x, 1=2x, 2=3x and 3=4x. Code 0 adds S1, 1 adds S2, 2 adds S3 and 3 adds S4. No other switch is on.
- R7: In phase 2 of the negative half-wave, S6, S7 and S8 are on, plus one switch that depends on the gain. Code 0 adds S12, 1 adds S11, 2 adds S10 and 3 adds S9. No other switch is on.
- R8: `mod_en` equals `duty` during phase 2 and is 0 at all other times.
- R9: `gain_sel` and `neg_half` are captured on the clock edge that starts phase 1. A change at any other time has no effect on `sw_en` until the next phase 1.
- R10: While `rst_n` is low, every output is low. After release, the sequence spends one gap cycle and then starts phase 1 using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_sel | input | 2 | Boost code: 0=1x, 1=2x, 2=3x, 3=4x |
| neg_half | input | 1 | 1 selects the negative half-wave |
| duty | input | 1 | Duty bit from the modulator |
| dead_cycles | input | DT_W | Length of each all-off gap (0 acts as 1) |
| phase_cycles | input | PER_W | Length of each phase (0 acts as 1) |
| phase1 | output | 1 | Charge phase active |
| phase2 | output | 1 | Discharge phase active |
| sw_en | output | 12 | Topology switch enables, bit k-1 drives Sk |
| mod_en | output | 1 | Modulated output switch enable |

## Verification
The hardest case to reach from the ports is a gain or polarity change made while a phase is already running. The captured value is not visible directly, so its only trace is the switch pattern of the rest of that cycle. The bench therefore changes `gain_sel` and `neg_half` in the first cycle of every phase 1. It then checks that the remaining charge and discharge patterns still match the old setting, and that the next cycle matches the new one. Every gain and polarity pair is swept this way under several gap and phase lengths, including the zero-as-one cases.

// File: rtl/sc_seq_pkg.sv
`timescale 1ns/1ps
package sc_seq_pkg;
   localparam int NUM_TOPO_SW = 12;

   typedef enum logic [1:0] {
      ST_GAP_CHG = 2'd0,
      ST_CHARGE  = 2'd1,
      ST_GAP_DIS = 2'd2,
      ST_DISCH   = 2'd3
   } seq_st_t;
endpackage

// File: rtl/sc_phase_gen.sv
`timescale 1ns/1ps
module sc_phase_gen
   import sc_seq_pkg::*;
#(
   parameter int DT_W  = 4,
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DT_W-1:0]  dead_cycles,
   input  logic [PER_W-1:0] phase_cycles,
   output seq_st_t          state,
   output logic             load_cfg
);
   localparam int CW = (DT_W > PER_W) ? DT_W : PER_W;

   logic [CW-1:0] cnt;
   logic [CW-1:0] dead_ld, phase_ld, next_ld;
   seq_st_t       nxt;

   assign dead_ld  = (dead_cycles == '0)  ? '0 : CW'(dead_cycles - 1'b1);
   assign phase_ld = (phase_cycles == '0) ? '0 : CW'(phase_cycles - 1'b1);
   assign nxt      = seq_st_t'(state + 2'd1);
   assign next_ld  = (nxt == ST_GAP_CHG || nxt == ST_GAP_DIS) ? dead_ld : phase_ld;
   assign load_cfg = (state == ST_GAP_CHG) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_GAP_CHG;
         cnt   <= '0;
      end else if (cnt == '0) begin
         state <= nxt;
         cnt   <= next_ld;
      end else begin
         cnt   <= cnt - 1'b1;
      end
   end

   // R1: states advance only in charge/gap/discharge/gap order
   assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != $past(state)) |-> (state == seq_st_t'($past(state) + 2'd1)));
endmodule

// File: rtl/sc_cfg_latch.sv
`timescale 1ns/1ps
module sc_cfg_latch #(
   parameter int G_W = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [G_W-1:0] gain_in,
   input  logic           neg_in,
   output logic [G_W-1:0] gain_q,
   output logic           neg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= '0;
         neg_q  <= 1'b0;
      end else if (load) begin
         gain_q <= gain_in;
         neg_q  <= neg_in;
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(gain_q) && $stable(neg_q)));
endmodule

// File: rtl/sc_switch_decode.sv
`timescale 1ns/1ps
module sc_switch_decode
   import sc_seq_pkg::*;
#(
   parameter int NSW = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           charge,
   input  logic           disch,
   input  logic [1:0]     gain,
   input  logic           neg,
   input  logic           duty,
   output logic [NSW-1:0] sw_en,
   output logic           mod_en
);
   if (NSW != NUM_TOPO_SW) begin : g_bad_nsw
      $error("sc_switch_decode: topology needs exactly 12 switches");
   end

   for (genvar k = 0; k < NSW; k++) begin : g_sw
      localparam int SN = k + 1;
      logic on_chg, on_pos, on_neg;
      assign on_chg = ((SN >= 2 && SN <= 4) || (SN >= 9 && SN <= 11)) ||
                      (SN == 1 && !neg) || (SN == 12 && neg);
      assign on_pos = (SN >= 5 && SN <= 7) || (SN == int'(gain) + 1);
      assign on_neg = (SN >= 6 && SN <= 8) || (SN == 12 - int'(gain));
      assign sw_en[k] = (charge && on_chg) || (disch && (neg ? on_neg : on_pos));
   end

   assign mod_en = disch & duty;

   assert_gap_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(charge || disch) |-> (sw_en == '0 && !mod_en));
   assert_mod_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mod_en |-> disch);
   assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      charge |-> (sw_en[7:4] == 4'b0));
   assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      disch |-> ($countones(sw_en) == 4));
endmodule

// File: rtl/sc_inv_sequencer.sv
`timescale 1ns/1ps
module sc_inv_sequencer
   import sc_seq_pkg::*;
#(
   parameter int DT_W  = 4,
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       gain_sel,
   input  logic             neg_half,
   input  logic             duty,
   input  logic [DT_W-1:0]  dead_cycles,
   input  logic [PER_W-1:0] phase_cycles,
   output logic             phase1,
   output logic             phase2,
   output logic [11:0]      sw_en,
   output logic             mod_en
);
   if (DT_W < 1 || DT_W > 8) begin : g_bad_dt
      $error("sc_inv_sequencer: DT_W must be 1..8");
   end
   if (PER_W < 1 || PER_W > 16) begin : g_bad_per
      $error("sc_inv_sequencer: PER_W must be 1..16");
   end

   seq_st_t    st;
   logic       load_cfg;
   logic [1:0] gain_q;
   logic       neg_q;

   sc_phase_gen #(.DT_W(DT_W), .PER_W(PER_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .dead_cycles(dead_cycles),
      .phase_cycles(phase_cycles), .state(st), .load_cfg(load_cfg));

   sc_cfg_latch #(.G_W(2)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load_cfg), .gain_in(gain_sel),
      .neg_in(neg_half), .gain_q(gain_q), .neg_q(neg_q));

   assign phase1 = (st == ST_CHARGE);
   assign phase2 = (st == ST_DISCH);

   sc_switch_decode #(.NSW(NUM_TOPO_SW)) u_dec (
      .clk(clk), .rst_n(rst_n), .charge(phase1), .disch(phase2),
      .gain(gain_q), .neg(neg_q), .duty(duty), .sw_en(sw_en), .mod_en(mod_en));

   assert_nonoverlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase1 && phase2));
   assert_phase_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase1) |-> !phase2);
endmodule

// File: tb/sc_inv_sequencer_test.sv
`timescale 1ns/1ps
module sc_inv_sequencer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  gain_sel = 2'd3;
   logic        neg_half = 1'b0;
   logic        duty = 1'b0;
   logic [3:0]  dead_cycles = 4'd2;
   logic [7:0]  phase_cycles = 8'd3;
   logic        phase1, phase2, mod_en;
   logic [11:0] sw_en;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sc_inv_sequencer #(.DT_W(4), .PER_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .gain_sel(gain_sel), .neg_half(neg_half),
      .duty(duty), .dead_cycles(dead_cycles), .phase_cycles(phase_cycles),
      .phase1(phase1), .phase2(phase2), .sw_en(sw_en), .mod_en(mod_en));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] exp_ph1(input bit neg);
      logic [11:0] v = 12'b0;
      v[1] = 1'b1; v[2] = 1'b1; v[3] = 1'b1;
      v[8] = 1'b1; v[9] = 1'b1; v[10] = 1'b1;
      if (neg) v[11] = 1'b1; else v[0] = 1'b1;
      return v;
   endfunction

   function automatic logic [11:0] exp_ph2(input int g, input bit neg);
      logic [11:0] v = 12'b0;
      if (!neg) begin
         v[4] = 1'b1; v[5] = 1'b1; v[6] = 1'b1;
         v[g] = 1'b1;
      end else begin
         v[5] = 1'b1; v[6] = 1'b1; v[7] = 1'b1;
         v[11 - g] = 1'b1;
      end
      return v;
   endfunction

   task automatic step();
      @(negedge clk);
      duty = ~duty;
      #1;
   endtask

   task automatic wait_rise();
      bit prev;
      int guard = 0;
      do begin
         prev = phase1;
         step();
         guard++;
      end while (!(phase1 && !prev) && guard < 2000);
   endtask

   // Entry: first cycle of phase 1. New inputs are applied here (R9 mid-phase change).
   task automatic run_period(input int g, input bit neg, input int ng, input bit nn,
                             input int dexp, input int pexp);
      int n;
      gain_sel = 2'(ng);
      neg_half = nn;
      n = 0;
      while (phase1 && n < 1000) begin
         chk(sw_en == exp_ph1(neg), neg ? "R5 ph1 set (R9 hold)" : "R4 ph1 set (R9 hold)",
             sw_en, exp_ph1(neg));
         chk(!phase2 && !mod_en, "R1/R8 ph1 exclusivity", {phase2, mod_en}, 0);
         n++; step();
      end
      chk(n == pexp, "R3 phase1 length", n, pexp);
      n = 0;
      while (!phase1 && !phase2 && n < 1000) begin
         chk(sw_en == 12'b0 && !mod_en, "R1 gap all off", {mod_en, sw_en}, 0);
         n++; step();
      end
      chk(n == dexp, "R2 gap before phase2", n, dexp);
      n = 0;
      while (phase2 && n < 1000) begin
         chk(sw_en == exp_ph2(g, neg), neg ? "R7 ph2 set (R9 hold)" : "R6 ph2 set (R9 hold)",
             sw_en, exp_ph2(g, neg));
         chk(mod_en == duty && !phase1, "R8 mod follows duty", mod_en, duty);
         n++; step();
      end
      chk(n == pexp, "R3 phase2 length", n, pexp);
      n = 0;
      while (!phase1 && !phase2 && n < 1000) begin
         chk(sw_en == 12'b0 && !mod_en, "R1 gap all off", {mod_en, sw_en}, 0);
         n++; step();
      end
      chk(n == dexp, "R2 gap before phase1", n, dexp);
   endtask

   initial begin
      int cur_g, cur_n;
      int dts[5] = '{0, 1, 5, 15, 2};
      int pers[5] = '{1, 3, 2, 4, 0};
      duty = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(sw_en == 12'b0 && !phase1 && !phase2 && !mod_en, "R10 reset outputs low",
          {phase1, phase2, mod_en, sw_en}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!phase1 && sw_en == 12'b0, "R10 gap after reset", {phase1, sw_en}, 0);
      step();
      chk(phase1 == 1'b1, "R10 phase1 after one gap cycle", phase1, 1);
      chk(sw_en == exp_ph1(1'b0), "R10 first phase1 set", sw_en, exp_ph1(1'b0));
      cur_g = 3; cur_n = 0;
      foreach (dts[c]) begin
         dead_cycles  = 4'(dts[c]);
         phase_cycles = 8'(pers[c]);
         wait_rise();
         wait_rise();
         for (int i = 0; i < 8; i++) begin
            run_period(cur_g, cur_n[0], i >> 1, i[0],
                       (dts[c] == 0) ? 1 : dts[c], (pers[c] == 0) ? 1 : pers[c]);
            cur_g = i >> 1;
            cur_n = i & 1;
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule